// File: doc/BRIEF.md
# Dual-Issue Pair Checker

This decode-stage unit looks at the two oldest pre-decoded instruction descriptors waiting in an instruction queue. It decides each cycle whether one or both of them leave for execution. Each descriptor is abstract. It holds a class code, two optional source register numbers, an optional destination register number, a flag-setting bit and a flag-reading bit. The unit does not decode full instruction words.

Pairing is legal only in a fixed older/younger class order. The unit also refuses any pair that has a register dependency, a condition-flag conflict, or a write to the program counter. The pop count goes back to the queue in the same cycle, so a refused younger instruction stays in the queue and becomes the older one of the next cycle.

Resources are allocated statically by slot. The older slot always owns write port 0 and read ports 0 and 1. The younger slot always owns write port 1 and read ports 2 and 3. The issue decision and the port and datapath selections reach the execute stage through one register stage.

Top module: `dual_issue_pair`

## Requirements
- R1: While rst_ni is low, issue_cnt_o, both write-port enables and register numbers, rp_en_o, rp_reg_o and both path codes are zero.
- R2: Descriptor layout with REG_W=4: class [3:0], src0 [7:4], src0 valid [8], src1 [12:9], src1 valid [13], dst [17:14], dst valid [18], sets flags [19], reads flags [20]. desc0_i is the older instruction. With vld_cnt_i 0 the pop count is 0. With 1 the pop count is 1 and desc1_i is ignored. The values 2 and 3 both mean two entries are present.
- R3: Class codes: 0 plain data-processing, 1 data-processing with register-specified shift, 2 multiply, 3 flag-setting multiply, 4 move without shift, 5 simple load, 6 other load, 7 simple store, 8 other store, 9 load/store-multiple, 10 status-register write, 11 exception-generating, 12 other control, 13 immediate branch, 14 IT, 15 NOP. A younger class 13, 14 or 15 pairs after any older class except 3, 9, 10, 11 and 12.
- R4: An older class 5 or 7 also pairs with a younger class 0 or 4, and with no other younger class outside R3.
- R5: An older class 4 pairs with a younger class 0, 1 or 4.
- R6: Every other class combination, including the reverse of every legal order, gives pop count 1.
- R7: A class-legal pair gives pop count 1 if the older instruction has a valid destination that the younger one reads through a valid source, or that the younger one also writes.
- R8: A class-legal pair gives pop count 1 in either of two cases: the older instruction sets flags and the younger one reads or sets them, or the older one reads flags and the younger one sets them.
- R9: A class-legal pair gives pop count 1 if either instruction has a valid destination equal to register 15, the program counter.
- R10: Write port 0 carries only the older instruction's destination and write port 1 only the younger one's. Read ports 0 and 1 carry the older instruction's src0 and src1, and read ports 2 and 3 carry the younger instruction's. Each port is enabled only if its slot issues and its field is valid, and its register number is zero otherwise.
- R11: Path codes are 1 for ALU (classes 0, 1, 4, 10), 2 for load/store (classes 5 to 9), 3 for multiply (classes 2, 3) and 0 for classes 11 to 15. A slot that does not issue shows 0.
- R12: pop_cnt_o is combinational from the current inputs. issue_cnt_o and every port and path output show the decision one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_cnt_i | input | 2 | Number of valid queue entries presented |
| desc0_i | input | DESC_W | Older instruction descriptor |
| desc1_i | input | DESC_W | Younger instruction descriptor |
| pop_cnt_o | output | 2 | Entries to pop from the queue this cycle |
| issue_cnt_o | output | 2 | Registered number of issued instructions |
| wp0_en_o | output | 1 | Write port 0 enable (older slot) |
| wp0_reg_o | output | REG_W | Write port 0 register number |
| wp1_en_o | output | 1 | Write port 1 enable (younger slot) |
| wp1_reg_o | output | REG_W | Write port 1 register number |
| rp_en_o | output | 4 | Read port enables |
| rp_reg_o | output | 4*REG_W | Read port register numbers, port k at bits k*REG_W |
| path0_o | output | 2 | Datapath code of the older slot |
| path1_o | output | 2 | Datapath code of the younger slot |

## Verification
The class-order rule and the hazard checks can judge the same pair in the same cycle. A pair that is legal by class can still be refused because of a dependency, a flag clash or a program-counter write. This case is provoked by holding a load followed by a data-processing instruction and sweeping every older destination against every younger source, including register 15. A second sweep covers all sixteen combinations of the four flag bits on legal pairs. Each vector is judged by the pop count in the same cycle and, one edge later, by whether write port 1, read ports 2 and 3 and the younger path code stay quiet.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_DP     = 4'd0,
    CLS_DP_RSH = 4'd1,
    CLS_MUL    = 4'd2,
    CLS_MULS   = 4'd3,
    CLS_MOV    = 4'd4,
    CLS_LD     = 4'd5,
    CLS_LD_X   = 4'd6,
    CLS_ST     = 4'd7,
    CLS_ST_X   = 4'd8,
    CLS_LSM    = 4'd9,
    CLS_MSR    = 4'd10,
    CLS_EXC    = 4'd11,
    CLS_CTL    = 4'd12,
    CLS_BIMM   = 4'd13,
    CLS_IT     = 4'd14,
    CLS_NOP    = 4'd15
  } cls_e;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_ALU  = 2'd1,
    PATH_LSU  = 2'd2,
    PATH_MAC  = 2'd3
  } path_e;

  function automatic path_e cls_path(cls_e c);
    path_e p;
    case (c)
      CLS_DP, CLS_DP_RSH, CLS_MOV, CLS_MSR:       p = PATH_ALU;
      CLS_LD, CLS_LD_X, CLS_ST, CLS_ST_X, CLS_LSM: p = PATH_LSU;
      CLS_MUL, CLS_MULS:                           p = PATH_MAC;
      default:                                     p = PATH_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dip_desc_split.sv
module dip_desc_split
  import dip_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DESC_W = 3*(REG_W+1)+6
) (
  input  logic [DESC_W-1:0] desc_i,
  output cls_e              cls_o,
  output logic [REG_W-1:0]  src0_o,
  output logic              src0_v_o,
  output logic [REG_W-1:0]  src1_o,
  output logic              src1_v_o,
  output logic [REG_W-1:0]  dst_o,
  output logic              dst_v_o,
  output logic              set_f_o,
  output logic              rd_f_o
);
  localparam int unsigned SRC0_LSB = CLS_W;
  localparam int unsigned SRC0_VB  = SRC0_LSB + REG_W;
  localparam int unsigned SRC1_LSB = SRC0_VB + 1;
  localparam int unsigned SRC1_VB  = SRC1_LSB + REG_W;
  localparam int unsigned DST_LSB  = SRC1_VB + 1;
  localparam int unsigned DST_VB   = DST_LSB + REG_W;
  localparam int unsigned SETF_B   = DST_VB + 1;
  localparam int unsigned RDF_B    = SETF_B + 1;

  assign cls_o    = cls_e'(desc_i[CLS_W-1:0]);
  assign src0_o   = desc_i[SRC0_LSB +: REG_W];
  assign src0_v_o = desc_i[SRC0_VB];
  assign src1_o   = desc_i[SRC1_LSB +: REG_W];
  assign src1_v_o = desc_i[SRC1_VB];
  assign dst_o    = desc_i[DST_LSB +: REG_W];
  assign dst_v_o  = desc_i[DST_VB];
  assign set_f_o  = desc_i[SETF_B];
  assign rd_f_o   = desc_i[RDF_B];

endmodule

// File: rtl/dip_pair_rule.sv
module dip_pair_rule
  import dip_pkg::*;
(
  input  cls_e cls0_i,
  input  cls_e cls1_i,
  output logic pair_ok_o
);
  logic first_any_ok;
  logic second_any;
  logic second_dp;
  logic second_dp_rsh;
  logic ok_any;
  logic ok_ls;
  logic ok_mov;

  always_comb begin
    // older slot may host a trailing branch/IT/NOP unless it is a heavy control op
    first_any_ok  = !(cls0_i inside {CLS_MULS, CLS_LSM, CLS_MSR, CLS_EXC, CLS_CTL});
    second_any    = cls1_i inside {CLS_BIMM, CLS_IT, CLS_NOP};
    second_dp     = cls1_i inside {CLS_DP, CLS_MOV};
    second_dp_rsh = cls1_i inside {CLS_DP, CLS_DP_RSH, CLS_MOV};
    ok_any        = first_any_ok && second_any;
    ok_ls         = (cls0_i inside {CLS_LD, CLS_ST}) && second_dp;
    ok_mov        = (cls0_i == CLS_MOV) && second_dp_rsh;
    pair_ok_o     = ok_any || ok_ls || ok_mov;
  end

endmodule

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int unsigned REG_W = 4
) (
  input  logic [REG_W-1:0] dst0_i,
  input  logic             dst0_v_i,
  input  logic             set_f0_i,
  input  logic             rd_f0_i,
  input  logic [REG_W-1:0] src0_1_i,
  input  logic             src0_v1_i,
  input  logic [REG_W-1:0] src1_1_i,
  input  logic             src1_v1_i,
  input  logic [REG_W-1:0] dst1_i,
  input  logic             dst1_v_i,
  input  logic             set_f1_i,
  input  logic             rd_f1_i,
  output logic             hazard_o
);
  localparam logic [REG_W-1:0] PC_IDX = '1;

  logic raw;
  logic waw;
  logic flag_clash;
  logic pc_wr;

  always_comb begin
    raw        = dst0_v_i && ((src0_v1_i && (src0_1_i == dst0_i)) ||
                              (src1_v1_i && (src1_1_i == dst0_i)));
    waw        = dst0_v_i && dst1_v_i && (dst1_i == dst0_i);
    flag_clash = (set_f0_i && (set_f1_i || rd_f1_i)) || (rd_f0_i && set_f1_i);
    pc_wr      = (dst0_v_i && (dst0_i == PC_IDX)) || (dst1_v_i && (dst1_i == PC_IDX));
    hazard_o   = raw || waw || flag_clash || pc_wr;
  end

endmodule

// File: rtl/dip_issue_stage.sv
module dip_issue_stage
  import dip_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      issue_i,
  input  cls_e [1:0]                      cls_i,
  input  logic [1:0][REG_W-1:0]           src0_i,
  input  logic [1:0]                      src0_v_i,
  input  logic [1:0][REG_W-1:0]           src1_i,
  input  logic [1:0]                      src1_v_i,
  input  logic [1:0][REG_W-1:0]           dst_i,
  input  logic [1:0]                      dst_v_i,
  output logic [1:0]                      issue_o,
  output logic [1:0]                      wp_en_o,
  output logic [1:0][REG_W-1:0]           wp_reg_o,
  output logic [3:0]                      rp_en_o,
  output logic [3:0][REG_W-1:0]           rp_reg_o,
  output path_e [1:0]                     path_o
);
  localparam int unsigned SLOTS = 2;

  logic [SLOTS-1:0]              slot_on;
  logic [SLOTS-1:0]              wp_en_d;
  logic [SLOTS-1:0][REG_W-1:0]   wp_reg_d;
  logic [2*SLOTS-1:0]            rp_en_d;
  logic [2*SLOTS-1:0][REG_W-1:0] rp_reg_d;
  path_e [SLOTS-1:0]             path_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_on[g]      = issue_i > 2'(g);
    assign wp_en_d[g]      = slot_on[g] && dst_v_i[g];
    assign wp_reg_d[g]     = wp_en_d[g] ? dst_i[g] : '0;
    assign rp_en_d[2*g]    = slot_on[g] && src0_v_i[g];
    assign rp_en_d[2*g+1]  = slot_on[g] && src1_v_i[g];
    assign rp_reg_d[2*g]   = rp_en_d[2*g]   ? src0_i[g] : '0;
    assign rp_reg_d[2*g+1] = rp_en_d[2*g+1] ? src1_i[g] : '0;
    assign path_d[g]       = slot_on[g] ? cls_path(cls_i[g]) : PATH_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_o  <= '0;
      wp_en_o  <= '0;
      wp_reg_o <= '0;
      rp_en_o  <= '0;
      rp_reg_o <= '0;
      path_o   <= {SLOTS{PATH_NONE}};
    end else begin
      issue_o  <= issue_i;
      wp_en_o  <= wp_en_d;
      wp_reg_o <= wp_reg_d;
      rp_en_o  <= rp_en_d;
      rp_reg_o <= rp_reg_d;
      path_o   <= path_d;
    end
  end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DESC_W = 3*(REG_W+1)+6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           vld_cnt_i,
  input  logic [DESC_W-1:0]    desc0_i,
  input  logic [DESC_W-1:0]    desc1_i,
  output logic [1:0]           pop_cnt_o,
  output logic [1:0]           issue_cnt_o,
  output logic                 wp0_en_o,
  output logic [REG_W-1:0]     wp0_reg_o,
  output logic                 wp1_en_o,
  output logic [REG_W-1:0]     wp1_reg_o,
  output logic [3:0]           rp_en_o,
  output logic [4*REG_W-1:0]   rp_reg_o,
  output logic [1:0]           path0_o,
  output logic [1:0]           path1_o
);
  localparam int unsigned SLOTS = 2;

  logic [SLOTS-1:0][DESC_W-1:0] desc_w;
  cls_e [SLOTS-1:0]             cls_w;
  logic [SLOTS-1:0][REG_W-1:0]  src0_w;
  logic [SLOTS-1:0][REG_W-1:0]  src1_w;
  logic [SLOTS-1:0][REG_W-1:0]  dst_w;
  logic [SLOTS-1:0]             src0_v_w;
  logic [SLOTS-1:0]             src1_v_w;
  logic [SLOTS-1:0]             dst_v_w;
  logic [SLOTS-1:0]             set_f_w;
  logic [SLOTS-1:0]             rd_f_w;

  logic                         pair_ok;
  logic                         hazard;
  logic                         two_avail;
  logic [1:0]                   issue_w;

  logic [SLOTS-1:0]             wp_en_w;
  logic [SLOTS-1:0][REG_W-1:0]  wp_reg_w;
  logic [3:0][REG_W-1:0]        rp_reg_w;
  path_e [SLOTS-1:0]            path_w;

  assign desc_w[0] = desc0_i;
  assign desc_w[1] = desc1_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_split
    dip_desc_split #(.REG_W(REG_W), .DESC_W(DESC_W)) i_split (
      .desc_i   (desc_w[g]),
      .cls_o    (cls_w[g]),
      .src0_o   (src0_w[g]),
      .src0_v_o (src0_v_w[g]),
      .src1_o   (src1_w[g]),
      .src1_v_o (src1_v_w[g]),
      .dst_o    (dst_w[g]),
      .dst_v_o  (dst_v_w[g]),
      .set_f_o  (set_f_w[g]),
      .rd_f_o   (rd_f_w[g])
    );
  end

  dip_pair_rule i_rule (
    .cls0_i    (cls_w[0]),
    .cls1_i    (cls_w[1]),
    .pair_ok_o (pair_ok)
  );

  dip_hazard #(.REG_W(REG_W)) i_hazard (
    .dst0_i    (dst_w[0]),
    .dst0_v_i  (dst_v_w[0]),
    .set_f0_i  (set_f_w[0]),
    .rd_f0_i   (rd_f_w[0]),
    .src0_1_i  (src0_w[1]),
    .src0_v1_i (src0_v_w[1]),
    .src1_1_i  (src1_w[1]),
    .src1_v1_i (src1_v_w[1]),
    .dst1_i    (dst_w[1]),
    .dst1_v_i  (dst_v_w[1]),
    .set_f1_i  (set_f_w[1]),
    .rd_f1_i   (rd_f_w[1]),
    .hazard_o  (hazard)
  );

  // a count of 3 is read as "two or more present"
  assign two_avail = vld_cnt_i[1];

  always_comb begin
    if (vld_cnt_i == 2'd0)                issue_w = 2'd0;
    else if (two_avail && pair_ok && !hazard) issue_w = 2'd2;
    else                                  issue_w = 2'd1;
  end

  assign pop_cnt_o = issue_w;

  dip_issue_stage #(.REG_W(REG_W)) i_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue_w),
    .cls_i    (cls_w),
    .src0_i   (src0_w),
    .src0_v_i (src0_v_w),
    .src1_i   (src1_w),
    .src1_v_i (src1_v_w),
    .dst_i    (dst_w),
    .dst_v_i  (dst_v_w),
    .issue_o  (issue_cnt_o),
    .wp_en_o  (wp_en_w),
    .wp_reg_o (wp_reg_w),
    .rp_en_o  (rp_en_o),
    .rp_reg_o (rp_reg_w),
    .path_o   (path_w)
  );

  assign wp0_en_o  = wp_en_w[0];
  assign wp1_en_o  = wp_en_w[1];
  assign wp0_reg_o = wp_reg_w[0];
  assign wp1_reg_o = wp_reg_w[1];
  assign rp_reg_o  = rp_reg_w;
  assign path0_o   = path_w[0];
  assign path1_o   = path_w[1];

endmodule

// File: rtl/dip_chk.sv
module dip_chk
  import dip_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       vld_cnt_i,
  input logic [1:0]       pop_cnt_o,
  input logic [1:0]       issue_cnt_o,
  input logic             wp1_en_o,
  input cls_e             cls0_i,
  input cls_e             cls1_i,
  input logic [REG_W-1:0] dst0_i,
  input logic             dst0_v_i,
  input logic [REG_W-1:0] dst1_i,
  input logic             dst1_v_i,
  input logic [REG_W-1:0] s1_src0_i,
  input logic             s1_src0_v_i,
  input logic [REG_W-1:0] s1_src1_i,
  input logic             s1_src1_v_i,
  input logic             set_f0_i,
  input logic             rd_f0_i,
  input logic             set_f1_i,
  input logic             rd_f1_i
);
  localparam logic [REG_W-1:0] PC_IDX = '1;

  a_r2_none_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_cnt_i == 2'd0) |-> (pop_cnt_o == 2'd0));

  a_r2_single_when_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_cnt_i == 2'd1) |-> (pop_cnt_o == 2'd1));

  a_r12_issue_tracks_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (issue_cnt_o == $past(pop_cnt_o)));

  a_r4_ls_second_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop_cnt_o == 2'd2) && (cls0_i inside {CLS_LD, CLS_ST}))
      |-> (cls1_i inside {CLS_DP, CLS_MOV, CLS_BIMM, CLS_IT, CLS_NOP}));

  a_r6_no_mem_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_o == 2'd2) |-> !(cls1_i inside {CLS_LD, CLS_LD_X, CLS_ST, CLS_ST_X, CLS_LSM}));

  a_r7_no_dependency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop_cnt_o == 2'd2) && dst0_v_i)
      |-> !((s1_src0_v_i && (s1_src0_i == dst0_i)) ||
            (s1_src1_v_i && (s1_src1_i == dst0_i)) ||
            (dst1_v_i && (dst1_i == dst0_i))));

  a_r8_no_flag_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_o == 2'd2) |-> !((set_f0_i && (set_f1_i || rd_f1_i)) || (rd_f0_i && set_f1_i)));

  a_r9_no_pc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_o == 2'd2) |-> !((dst0_v_i && (dst0_i == PC_IDX)) || (dst1_v_i && (dst1_i == PC_IDX))));

  a_r10_wp1_only_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp1_en_o |-> (issue_cnt_o == 2'd2));

endmodule

bind dual_issue_pair dip_chk #(.REG_W(REG_W)) i_dip_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vld_cnt_i   (vld_cnt_i),
  .pop_cnt_o   (pop_cnt_o),
  .issue_cnt_o (issue_cnt_o),
  .wp1_en_o    (wp1_en_o),
  .cls0_i      (cls_w[0]),
  .cls1_i      (cls_w[1]),
  .dst0_i      (dst_w[0]),
  .dst0_v_i    (dst_v_w[0]),
  .dst1_i      (dst_w[1]),
  .dst1_v_i    (dst_v_w[1]),
  .s1_src0_i   (src0_w[1]),
  .s1_src0_v_i (src0_v_w[1]),
  .s1_src1_i   (src1_w[1]),
  .s1_src1_v_i (src1_v_w[1]),
  .set_f0_i    (set_f_w[0]),
  .rd_f0_i     (rd_f_w[0]),
  .set_f1_i    (set_f_w[1]),
  .rd_f1_i     (rd_f_w[1])
);

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
  localparam int RW = 4;
  localparam int DW = 21;

  localparam int C_DP = 0, C_DPR = 1, C_MUL = 2, C_MULS = 3, C_MOV = 4, C_LD = 5,
                 C_LDX = 6, C_ST = 7, C_STX = 8, C_LSM = 9, C_MSR = 10, C_EXC = 11,
                 C_CTL = 12, C_BIMM = 13, C_IT = 14, C_NOP = 15;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    vld = 2'd0;
  logic [DW-1:0] d0 = '0;
  logic [DW-1:0] d1 = '0;
  logic [1:0]    pop_cnt_o, issue_cnt_o, path0_o, path1_o;
  logic          wp0_en_o, wp1_en_o;
  logic [RW-1:0] wp0_reg_o, wp1_reg_o;
  logic [3:0]    rp_en_o;
  logic [4*RW-1:0] rp_reg_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_issue_pair i_dual_issue_pair (
    .clk_i(clk), .rst_ni(rst_ni), .vld_cnt_i(vld), .desc0_i(d0), .desc1_i(d1),
    .pop_cnt_o(pop_cnt_o), .issue_cnt_o(issue_cnt_o),
    .wp0_en_o(wp0_en_o), .wp0_reg_o(wp0_reg_o), .wp1_en_o(wp1_en_o), .wp1_reg_o(wp1_reg_o),
    .rp_en_o(rp_en_o), .rp_reg_o(rp_reg_o), .path0_o(path0_o), .path1_o(path1_o)
  );

  function automatic logic [DW-1:0] mk(int c, int s0v, int s0, int s1v, int s1,
                                       int dv, int d, int sf, int rf);
    return {1'(rf), 1'(sf), 1'(dv), 4'(d), 1'(s1v), 4'(s1), 1'(s0v), 4'(s0), 4'(c)};
  endfunction

  function automatic int path_of(int c);
    if (c == C_DP || c == C_DPR || c == C_MOV || c == C_MSR) return 1;
    if (c >= C_LD && c <= C_LSM) return 2;
    if (c == C_MUL || c == C_MULS) return 3;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic predict(logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] v,
                         output int p, output string tag);
    int c0, c1;
    bit first_a, sec_a, ok, pc, dep, flg;
    if (v == 2'd0) begin p = 0; tag = "R2"; return; end
    if (v == 2'd1) begin p = 1; tag = "R2"; return; end
    c0 = int'(a[3:0]);
    c1 = int'(b[3:0]);
    first_a = !(c0 == C_MULS || c0 == C_LSM || c0 == C_MSR || c0 == C_EXC || c0 == C_CTL);
    sec_a   = (c1 == C_BIMM || c1 == C_IT || c1 == C_NOP);
    ok = (first_a && sec_a) ||
         ((c0 == C_LD || c0 == C_ST) && (c1 == C_DP || c1 == C_MOV)) ||
         ((c0 == C_MOV) && (c1 == C_DP || c1 == C_DPR || c1 == C_MOV));
    if (sec_a) tag = "R3";
    else if (c0 == C_LD || c0 == C_ST) tag = "R4";
    else if (c0 == C_MOV) tag = "R5";
    else tag = "R6";
    if (!ok) begin p = 1; return; end
    pc  = (a[18] && a[17:14] == 4'd15) || (b[18] && b[17:14] == 4'd15);
    dep = a[18] && ((b[8] && b[7:4] == a[17:14]) || (b[13] && b[12:9] == a[17:14]) ||
                    (b[18] && b[17:14] == a[17:14]));
    flg = (a[19] && (b[19] || b[20])) || (a[20] && b[19]);
    if (pc)       begin p = 1; tag = "R9"; end
    else if (dep) begin p = 1; tag = "R7"; end
    else if (flg) begin p = 1; tag = "R8"; end
    else p = 2;
  endtask

  task automatic apply(logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] v);
    int p;
    string tag;
    bit on0, on1;
    logic [4*RW-1:0] erp;
    @(negedge clk);
    d0 = a; d1 = b; vld = v;
    #1;
    predict(a, b, v, p, tag);
    chk(tag, "pop", int'(pop_cnt_o), p);
    @(posedge clk);
    #1;
    on0 = (p >= 1);
    on1 = (p == 2);
    erp = {(on1 && b[13]) ? b[12:9] : 4'd0, (on1 && b[8]) ? b[7:4] : 4'd0,
           (on0 && a[13]) ? a[12:9] : 4'd0, (on0 && a[8]) ? a[7:4] : 4'd0};
    chk("R12", "issue", int'(issue_cnt_o), p);
    chk("R10", "wp0_en", int'(wp0_en_o), int'(on0 && a[18]));
    chk("R10", "wp0_reg", int'(wp0_reg_o), (on0 && a[18]) ? int'(a[17:14]) : 0);
    chk("R10", "wp1_en", int'(wp1_en_o), int'(on1 && b[18]));
    chk("R10", "wp1_reg", int'(wp1_reg_o), (on1 && b[18]) ? int'(b[17:14]) : 0);
    chk("R10", "rp_en", int'(rp_en_o),
        int'({on1 && b[13], on1 && b[8], on0 && a[13], on0 && a[8]}));
    chk("R10", "rp_reg", int'(rp_reg_o), int'(erp));
    chk("R11", "path0", int'(path0_o), on0 ? path_of(int'(a[3:0])) : 0);
    chk("R11", "path1", int'(path1_o), on1 ? path_of(int'(b[3:0])) : 0);
    vectors++;
  endtask

  initial begin
    #800000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=done", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle during reset
    chk("R1", "issue", int'(issue_cnt_o), 0);
    chk("R1", "wp_en", int'({wp1_en_o, wp0_en_o}), 0);
    chk("R1", "wp_reg", int'({wp1_reg_o, wp0_reg_o}), 0);
    chk("R1", "rp_en", int'(rp_en_o), 0);
    chk("R1", "rp_reg", int'(rp_reg_o), 0);
    chk("R1", "path", int'({path1_o, path0_o}), 0);
    vectors++;
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: valid-count handling on a legal pair and on a reversed pair
    for (int v = 0; v < 4; v++) begin
      apply(mk(C_LD, 1, 2, 1, 3, 1, 1, 0, 0), mk(C_DP, 1, 5, 1, 6, 1, 4, 0, 0), 2'(v));
      apply(mk(C_DP, 1, 2, 1, 3, 1, 1, 0, 0), mk(C_LD, 1, 5, 1, 6, 1, 4, 0, 0), 2'(v));
    end

    // R3 R4 R5 R6: every class order, hazard-free operands
    for (int c0 = 0; c0 < 16; c0++)
      for (int c1 = 0; c1 < 16; c1++)
        apply(mk(c0, 1, 2, 1, 3, 1, 1, 0, 0), mk(c1, 1, 5, 1, 6, 1, 4, 0, 0), 2'd2);

    // R7 R9: legal class pair, sweep older destination against younger source
    for (int dd = 0; dd < 16; dd++)
      for (int s = 0; s < 16; s++)
        apply(mk(C_LD, 1, (dd + 1) % 16, 0, 0, 1, dd, 0, 0),
              mk(C_DP, 1, s, 1, (s + 3) % 16, 1, (s + 8) % 16, 0, 0), 2'd2);

    // R7: write-after-write sweep
    for (int dd = 0; dd < 16; dd++)
      apply(mk(C_MOV, 0, 0, 0, 0, 1, 7, 0, 0), mk(C_DP, 0, 0, 0, 0, 1, dd, 0, 0), 2'd3);

    // R8: all flag-bit combinations on two legal pairs
    for (int f = 0; f < 16; f++) begin
      apply(mk(C_MOV, 1, 2, 0, 0, 1, 1, f & 1, (f >> 1) & 1),
            mk(C_DP, 1, 5, 1, 6, 1, 4, (f >> 2) & 1, (f >> 3) & 1), 2'd2);
      apply(mk(C_DP, 1, 2, 1, 3, 1, 1, f & 1, (f >> 1) & 1),
            mk(C_BIMM, 0, 0, 0, 0, 0, 0, (f >> 2) & 1, (f >> 3) & 1), 2'd2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule